// File: doc/BRIEF.md
# Canonical Signed-Digit Recoder

This block converts a two's complement multiplier word into its canonical signed-digit form: the unique digit string over {-1, 0, +1} that has the same value as the word and never places two nonzero digits side by side. A multiplier that adds or subtracts the multiplicand once per nonzero digit does the fewest possible operations when it uses this string.

The word is captured when `start` is pulsed. The block then walks it from the least significant bit upward, one bit per clock. It carries one bit of state that says whether the walk is currently inside a run of ones, and it looks at the next higher bit to decide how the run ends. The word is sign-extended by one bit, so a WIDTH-bit input yields WIDTH+1 digits. Each digit is presented on a registered strobe, and a one-cycle completion flag follows the last digit. Reissuing `start` during a scan drops the old word and begins the new one with the run state cleared.

Top module: `csd_recoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `digit_stb`, `scan_done` and `digit_code` all zero.
- R2: When `start` is sampled high, `digit_stb` stays low for the next cycle. It then stays high for exactly WIDTH+1 consecutive cycles, one digit per cycle.
- R3: Digit encoding is 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. The code 2'b10 never appears, and `digit_code` is 2'b00 whenever `digit_stb` is low.
- R4: Digits come least significant first. Digit k has weight 2^k, and the weighted sum of all WIDTH+1 digits equals the signed value of the captured word.
- R5: No two consecutive digits of a scan are both nonzero.
- R6: Each digit follows this rule, where s is the current bit plus the run bit and the reference is the next higher bit of the sign-extended word. If s = 0, the digit is 0 and the run bit clears. If s = 2, the digit is 0 and the run bit sets. If s = 1 and the reference is 1, the digit is -1 and the run bit sets. If s = 1 and the reference is 0, the digit is +1 and the run bit clears. For example, for WIDTH = 8, the word 0x6E gives +1 at position 7, -1 at positions 4 and 1, and 0 elsewhere.
- R7: `scan_done` is high for exactly one cycle, the cycle right after the last digit, and is low at every other time.
- R8: A `start` pulse during a scan abandons the old word. The run bit clears, and the new word's full WIDTH+1 digits follow with R2 timing.
- R9: Reset during a scan stops the digits at the next edge. Without a new `start`, no further strobe or done flag appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture `mult_word` and begin a scan |
| mult_word | input | WIDTH | Two's complement multiplier word |
| digit_stb | output | 1 | A digit is present on `digit_code` |
| digit_code | output | 2 | Signed digit: 00 zero, 01 plus one, 11 minus one |
| scan_done | output | 1 | One-cycle flag after the final digit |

## Verification
A table of hand-derived canonical strings exercises specific run shapes. These include a lone low-order one, alternating ones that must stay as +1 digits, a long run that collapses to +1/-1 pairs, and words made only of sign bits, such as -1, -64 and -128, where the run meets the sign extension. Any digit string that sums correctly but is not canonical fails this comparison. An exhaustive sweep of every 8-bit word then checks the value and the no-adjacent-nonzero property, which exposes any error in the carry or reference choice for uncommon bit patterns. Directed cases restart a scan while the run bit is set, to show it is cleared, and apply reset in mid-scan, to show the stream stops.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } csd_digit_e;

  typedef struct packed {
    csd_digit_e digit;
    logic       carry_next;
  } csd_step_t;

endpackage

// File: rtl/csd_digit_rule.sv
`timescale 1ns/1ps
module csd_digit_rule
  import csd_pkg::*;
(
  input  logic      cur_bit,
  input  logic      ref_bit,
  input  logic      carry_in,
  output csd_step_t step
);

  always_comb begin
    unique case ({cur_bit, carry_in})
      2'b00: begin
        step.digit      = DIG_ZERO;
        step.carry_next = 1'b0;
      end
      2'b11: begin
        step.digit      = DIG_ZERO;
        step.carry_next = 1'b1;
      end
      default: begin
        if (ref_bit) begin
          step.digit      = DIG_NEG;
          step.carry_next = 1'b1;
        end else begin
          step.digit      = DIG_POS;
          step.carry_next = 1'b0;
        end
      end
    endcase
  end

endmodule

// File: rtl/csd_bit_stream.sv
`timescale 1ns/1ps
module csd_bit_stream #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] word,
  output logic             cur_bit,
  output logic             ref_bit
);

  localparam int SR_W = WIDTH + 2;

  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= {word[WIDTH-1], word[WIDTH-1], word};
    end else if (shift) begin
      sr <= {sr[SR_W-1], sr[SR_W-1:1]};
    end
  end

  assign cur_bit = sr[0];
  assign ref_bit = sr[1];

endmodule

// File: rtl/csd_scan_ctrl.sv
`timescale 1ns/1ps
module csd_scan_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last,
  output logic done
);

  localparam int NDIG  = WIDTH + 1;
  localparam int IDX_W = $clog2(NDIG + 1);

  logic [IDX_W-1:0] idx;
  logic             fin_q;

  assign last = busy && (idx == IDX_W'(WIDTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      fin_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= fin_q && !start;
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        fin_q <= 1'b0;
      end else begin
        fin_q <= last;
        if (busy) begin
          idx <= idx + IDX_W'(1);
          if (last) begin
            busy <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/csd_recoder.sv
`timescale 1ns/1ps
module csd_recoder
  import csd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mult_word,
  output logic             digit_stb,
  output logic [1:0]       digit_code,
  output logic             scan_done
);

  logic      busy;
  logic      last;
  logic      cur_bit;
  logic      ref_bit;
  logic      run_bit;
  csd_step_t step;

  csd_scan_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .last  (last),
    .done  (scan_done)
  );

  csd_bit_stream #(.WIDTH(WIDTH)) u_stream (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .shift   (busy && !start),
    .word    (mult_word),
    .cur_bit (cur_bit),
    .ref_bit (ref_bit)
  );

  csd_digit_rule u_rule (
    .cur_bit  (cur_bit),
    .ref_bit  (ref_bit),
    .carry_in (run_bit),
    .step     (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_bit    <= 1'b0;
      digit_stb  <= 1'b0;
      digit_code <= DIG_ZERO;
    end else if (start) begin
      run_bit    <= 1'b0;
      digit_stb  <= 1'b0;
      digit_code <= DIG_ZERO;
    end else if (busy) begin
      run_bit    <= step.carry_next;
      digit_stb  <= 1'b1;
      digit_code <= step.digit;
    end else begin
      digit_stb  <= 1'b0;
      digit_code <= DIG_ZERO;
    end
  end

endmodule

// File: rtl/csd_recoder_chk.sv
`timescale 1ns/1ps
module csd_recoder_chk #(
  parameter int WIDTH = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       digit_stb,
  input logic [1:0] digit_code,
  input logic       scan_done
);

  localparam int CW = $clog2(WIDTH + 3);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
    end else if (digit_stb) begin
      run_len <= run_len + CW'(1);
    end else begin
      run_len <= '0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!digit_stb && !scan_done && digit_code == 2'b00));

  assert_digit_count_R2: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> run_len == CW'(WIDTH + 1));

  assert_start_gap_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> !digit_stb);

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (rst)
    digit_stb |-> digit_code != 2'b10);

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (rst)
    !digit_stb |-> digit_code == 2'b00);

  assert_no_adjacent_R5: assert property (@(posedge clk) disable iff (rst)
    (digit_stb && $past(digit_stb) && $past(digit_code) != 2'b00)
      |-> digit_code == 2'b00);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (!digit_stb && $past(digit_stb)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

endmodule

bind csd_recoder csd_recoder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .digit_stb  (digit_stb),
  .digit_code (digit_code),
  .scan_done  (scan_done)
);

// File: tb/sim_csd_recoder.sv
`timescale 1ns/1ps
module sim_csd_recoder;

  localparam int WIDTH = 8;
  localparam int NDIG  = WIDTH + 1;
  localparam int NVEC  = 10;

  // word, expected +1 mask, expected -1 mask (bit k = digit k)
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h6E, 9'h080, 9'h012},
    {8'hFF, 9'h000, 9'h001},
    {8'h80, 9'h000, 9'h080},
    {8'h55, 9'h055, 9'h000},
    {8'h7F, 9'h080, 9'h001},
    {8'h00, 9'h000, 9'h000},
    {8'h03, 9'h004, 9'h001},
    {8'hAA, 9'h02A, 9'h080},
    {8'h01, 9'h001, 9'h000},
    {8'hC0, 9'h000, 9'h040}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [WIDTH-1:0] mult_word = '0;
  logic             digit_stb;
  logic [1:0]       digit_code;
  logic             scan_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  csd_recoder #(.WIDTH(WIDTH)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mult_word  (mult_word),
    .digit_stb  (digit_stb),
    .digit_code (digit_code),
    .scan_done  (scan_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [WIDTH-1:0] w);
    @(negedge clk);
    start = 1'b1;
    mult_word = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(output logic [NDIG-1:0] pos, output logic [NDIG-1:0] neg,
                         output bit stb_ok, output bit code_ok, output bit done_ok);
    stb_ok = 1'b1; code_ok = 1'b1; done_ok = 1'b1;
    pos = '0; neg = '0;
    if (digit_stb || scan_done) stb_ok = 1'b0;
    if (digit_code != 2'b00) code_ok = 1'b0;
    for (int k = 0; k < NDIG; k++) begin
      @(negedge clk);
      if (!digit_stb) stb_ok = 1'b0;
      if (scan_done) done_ok = 1'b0;
      case (digit_code)
        2'b00: ;
        2'b01: pos[k] = 1'b1;
        2'b11: neg[k] = 1'b1;
        default: code_ok = 1'b0;
      endcase
    end
    @(negedge clk);
    if (digit_stb) stb_ok = 1'b0;
    if (!scan_done) done_ok = 1'b0;
    if (digit_code != 2'b00) code_ok = 1'b0;
    @(negedge clk);
    if (scan_done) done_ok = 1'b0;
  endtask

  function automatic int digit_sum(input logic [NDIG-1:0] pos, input logic [NDIG-1:0] neg);
    int v = 0;
    for (int k = 0; k < NDIG; k++) begin
      if (pos[k]) v += (1 << k);
      if (neg[k]) v -= (1 << k);
    end
    return v;
  endfunction

  task automatic run_and_check(input logic [WIDTH-1:0] w, input bit exact,
                               input logic [NDIG-1:0] exp_pos, input logic [NDIG-1:0] exp_neg);
    logic [NDIG-1:0] pos, neg, nz;
    bit s_ok, c_ok, d_ok;
    pulse_start(w);
    collect(pos, neg, s_ok, c_ok, d_ok);
    nz = pos | neg;
    check(s_ok, "R2", $sformatf("strobe timing word=%0h", w), s_ok, 1);
    check(c_ok, "R3", $sformatf("digit encoding word=%0h", w), c_ok, 1);
    check(d_ok, "R7", $sformatf("done timing word=%0h", w), d_ok, 1);
    check(digit_sum(pos, neg) == int'($signed(w)), "R4",
          $sformatf("digit sum word=%0h", w), digit_sum(pos, neg), int'($signed(w)));
    check((nz & (nz >> 1)) == '0, "R5",
          $sformatf("adjacent nonzero word=%0h", w), nz, 0);
    if (exact) begin
      check(pos == exp_pos, "R6", $sformatf("plus mask word=%0h", w), pos, exp_pos);
      check(neg == exp_neg, "R6", $sformatf("minus mask word=%0h", w), neg, exp_neg);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NDIG-1:0] pos, neg;
    bit s_ok, c_ok, d_ok;
    bit seen;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!digit_stb && !scan_done && digit_code == 2'b00, "R1", "outputs under reset",
          {digit_stb, scan_done, digit_code}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!digit_stb && !scan_done && digit_code == 2'b00, "R1", "outputs after reset",
          {digit_stb, scan_done, digit_code}, 0);

    // R6: table of canonical strings
    for (int i = 0; i < NVEC; i++) begin
      run_and_check(VEC[i][25:18], 1'b1, VEC[i][17:9], VEC[i][8:0]);
    end

    // R4, R5: every word
    for (int w = 0; w < (1 << WIDTH); w++) begin
      run_and_check(WIDTH'(w), 1'b0, '0, '0);
    end

    // R8: restart while the run bit is set (0x6E has carry 1 after digit 1)
    pulse_start(8'h6E);
    @(negedge clk);
    @(negedge clk);
    pulse_start(8'h03);
    collect(pos, neg, s_ok, c_ok, d_ok);
    check(s_ok && d_ok, "R8", "restart timing", {s_ok, d_ok}, 3);
    check(pos == 9'h004 && neg == 9'h001, "R8", "restart digits",
          {pos, neg}, {9'h004, 9'h001});

    // R9: reset in mid-scan
    pulse_start(8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!digit_stb && !scan_done, "R9", "strobe after mid-scan reset",
          {digit_stb, scan_done}, 0);
    rst = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < NDIG + 4; k++) begin
      @(negedge clk);
      if (digit_stb || scan_done) seen = 1'b1;
    end
    check(!seen, "R9", "activity without start after reset", seen, 0);

    // R3: idle code stays zero
    check(digit_code == 2'b00 && !digit_stb, "R3", "idle code", digit_code, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule